// File: doc/BRIEF.md
# Guarded Clock Source Selection Controller

This block decides which clock source a microcontroller-style clock unit runs from. Software asks for a new source through a 2-bit request code. Three codes pick sources derived from the main oscillator: main divided by two, main undivided, and the PLL output. The fourth code picks the sub oscillator. Software can also halt either oscillator, pick the length of the main oscillator settling wait, and ask for stop mode. The oscillators, the PLL and the glitch-free multiplexer are not part of this block. It drives their enables and models their settling with one wait counter per oscillator.

The controller applies the ordering rules that keep the chip on a running, settled clock. A request is refused when the oscillator it needs has been halted. An oscillator may only be halted while the chip runs from the other one. After an oscillator is re-enabled, nothing switches until its wait counter expires. Requests that arrive during a wait are held as one pending request. Stop mode is granted only when the PLL cannot be left running. Every refusal sets a sticky error flag.

Reset is active low. While it is held, the source returns to main divided by two, both halt bits clear and the wait selection goes to its longest value. When reset is released, both oscillator waits start again from zero.

Top module: `clk_src_guard`

## Requirements
- R1: The source codes are 00 = main/2, 01 = main undivided, 10 = PLL and 11 = sub. If a legal request arrives while `busy` is low, `cur_src` shows the new code after the next clock edge.
- R2: A request for code 00, 01 or 10 is refused while the main halt bit is set. `cur_src` stays unchanged and `err` goes high.
- R3: A request for code 11 is refused while the sub halt bit is set. `cur_src` stays unchanged and `err` goes high.
- R4: Setting the main halt bit is accepted only while the source (after any same-cycle switch) is 11. Setting the sub halt bit is accepted only while that source is 00, 01 or 10. A refused halt sets `err`. Each oscillator enable output is low while its halt bit is set. Clearing a halt bit is always accepted.
- R5: When an oscillator enable rises, `busy` goes high at once. The oscillator's ready output rises after its wait, and `busy` falls in the same cycle.
- R6: The main wait lasts 2^(WAIT_EXP_BASE + WAIT_EXP_STEP*sel) cycles, where sel is the 2-bit wait selection. The sub wait lasts 2^SUB_WAIT_EXP cycles. The wait selection resets to 3.
- R7: A legal request made while `busy` is high is held as the single pending request, and a later one replaces it. `cur_src` does not change while `busy` is high. The pending request is checked again and applied on the edge after `busy` falls.
- R8: `err` stays high until `err_clr` is pulsed. If an error is set in the same cycle as `err_clr`, the set wins.
- R9: While `rst_n` is low, `cur_src` is 00, both halt bits and the auto-halt bit are clear, nothing is pending and `err` is low. After release, the main wait runs at its longest setting, so `busy` stays high for 2^(WAIT_EXP_BASE+3*WAIT_EXP_STEP) cycles.
- R10: `stop_grant` is registered. It rises only if `stop_req` is high, `busy` is low, and either auto-halt is set or `cur_src` is 00. It stays high only while `stop_req` stays high and that source condition still holds, and it falls on the edge after `stop_req` falls.
- R11: While stop is granted with auto-halt set, `main_osc_en` is low. When the grant ends, the main oscillator restarts and its full wait runs again, with `busy` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset; forces main/2 |
| src_req_vld | input | 1 | One-cycle source change request |
| src_req_code | input | 2 | Requested source code |
| main_halt_wr | input | 1 | Write strobe for main halt bit |
| main_halt_val | input | 1 | Value written to main halt bit |
| sub_halt_wr | input | 1 | Write strobe for sub halt bit |
| sub_halt_val | input | 1 | Value written to sub halt bit |
| wait_sel_wr | input | 1 | Write strobe for main wait selection |
| wait_sel_val | input | 2 | Main wait selection value |
| auto_halt_wr | input | 1 | Write strobe for auto-halt-in-stop bit |
| auto_halt_val | input | 1 | Auto-halt-in-stop value |
| stop_req | input | 1 | Level request for stop mode |
| err_clr | input | 1 | Pulse to clear the error flag |
| cur_src | output | 2 | Active source code |
| busy | output | 1 | An oscillator wait is running |
| err | output | 1 | Sticky refusal flag |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Sub oscillator enable |
| main_rdy | output | 1 | Main oscillator settled |
| sub_rdy | output | 1 | Sub oscillator settled |
| stop_grant | output | 1 | Stop mode granted |

## Verification
The bench builds the block with WAIT_EXP_BASE=3, WAIT_EXP_STEP=1 and SUB_WAIT_EXP=4. The main wait then takes 8, 16, 32 or 64 cycles and the sub wait takes 16. With these short waits, the bench can check the exact cycle in which `busy` falls after reset, after a halt is cleared and after an auto-halted stop ends. It can also check that a queued request lands only after the wait. Because the reset default of 64 cycles differs from the 8 cycles programmed earlier, the bench shows that reset restores the longest setting.

// File: rtl/clk_src_guard_pkg.sv
package clk_src_guard_pkg;

   typedef enum logic [1:0] {
      SRC_MAIN_DIV2   = 2'b00,
      SRC_MAIN_DIRECT = 2'b01,
      SRC_MAIN_PLL    = 2'b10,
      SRC_SUB         = 2'b11
   } src_e;

   localparam int OSC_MAIN = 0;
   localparam int OSC_SUB  = 1;
   localparam int NUM_OSC  = 2;

   function automatic logic needs_main(input src_e s);
      return s != SRC_SUB;
   endfunction

endpackage

// File: rtl/csg_osc_timer.sv
module csg_osc_timer #(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] last,
   output logic             rdy
);
   logic [CNT_W-1:0] cnt_q;

   // Counts enabled cycles; ready after last+1 of them, cleared when disabled.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rdy   <= 1'b0;
      end else if (!en) begin
         cnt_q <= '0;
         rdy   <= 1'b0;
      end else if (!rdy) begin
         if (cnt_q == last) rdy   <= 1'b1;
         else               cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/csg_src_ctrl.sv
module csg_src_ctrl
   import clk_src_guard_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_vld,
   input  logic [1:0] req_code,
   input  logic       main_halt_wr,
   input  logic       main_halt_val,
   input  logic       sub_halt_wr,
   input  logic       sub_halt_val,
   input  logic       err_clr,
   input  logic       busy,
   output src_e       cur_src,
   output logic       main_halt,
   output logic       sub_halt,
   output logic       err
);
   src_e pend_q, pend_d, cur_d;
   logic pend_vld_q, pend_vld_d;
   logic main_halt_d, sub_halt_d, err_set;

   function automatic logic legal(input src_e s, input logic mh, input logic sh);
      return needs_main(s) ? !mh : !sh;
   endfunction

   always_comb begin
      cur_d       = cur_src;
      pend_d      = pend_q;
      pend_vld_d  = pend_vld_q;
      err_set     = 1'b0;
      if (req_vld) begin
         if (!legal(src_e'(req_code), main_halt, sub_halt)) begin
            err_set = 1'b1;
         end else if (busy) begin
            pend_d     = src_e'(req_code);
            pend_vld_d = 1'b1;
         end else begin
            cur_d      = src_e'(req_code);
            pend_vld_d = 1'b0;
         end
      end else if (pend_vld_q && !busy) begin
         pend_vld_d = 1'b0;
         if (legal(pend_q, main_halt, sub_halt)) cur_d   = pend_q;
         else                                    err_set = 1'b1;
      end

      main_halt_d = main_halt;
      if (main_halt_wr) begin
         if (!main_halt_val)            main_halt_d = 1'b0;
         else if (cur_d == SRC_SUB)     main_halt_d = 1'b1;
         else                           err_set     = 1'b1;
      end
      sub_halt_d = sub_halt;
      if (sub_halt_wr) begin
         if (!sub_halt_val)             sub_halt_d = 1'b0;
         else if (needs_main(cur_d))    sub_halt_d = 1'b1;
         else                           err_set    = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_src    <= SRC_MAIN_DIV2;
         pend_q     <= SRC_MAIN_DIV2;
         pend_vld_q <= 1'b0;
         main_halt  <= 1'b0;
         sub_halt   <= 1'b0;
         err        <= 1'b0;
      end else begin
         cur_src    <= cur_d;
         pend_q     <= pend_d;
         pend_vld_q <= pend_vld_d;
         main_halt  <= main_halt_d;
         sub_halt   <= sub_halt_d;
         err        <= err_set | (err & !err_clr);
      end
   end
endmodule

// File: rtl/csg_stop_gate.sv
module csg_stop_gate
   import clk_src_guard_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic stop_req,
   input  logic auto_halt,
   input  src_e cur_src,
   input  logic busy,
   output logic grant
);
   logic pll_safe;
   assign pll_safe = auto_halt || (cur_src == SRC_MAIN_DIV2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) grant <= 1'b0;
      else        grant <= stop_req && pll_safe && (grant || !busy);
   end
endmodule

// File: rtl/clk_src_guard.sv
module clk_src_guard
   import clk_src_guard_pkg::*;
#(
   parameter int WAIT_EXP_BASE = 10,
   parameter int WAIT_EXP_STEP = 3,
   parameter int SUB_WAIT_EXP  = 15,
   parameter int WAIT_SEL_W    = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  src_req_vld,
   input  logic [1:0]            src_req_code,
   input  logic                  main_halt_wr,
   input  logic                  main_halt_val,
   input  logic                  sub_halt_wr,
   input  logic                  sub_halt_val,
   input  logic                  wait_sel_wr,
   input  logic [WAIT_SEL_W-1:0] wait_sel_val,
   input  logic                  auto_halt_wr,
   input  logic                  auto_halt_val,
   input  logic                  stop_req,
   input  logic                  err_clr,
   output logic [1:0]            cur_src,
   output logic                  busy,
   output logic                  err,
   output logic                  main_osc_en,
   output logic                  sub_osc_en,
   output logic                  main_rdy,
   output logic                  sub_rdy,
   output logic                  stop_grant
);
   localparam int MAIN_EXP_MAX = WAIT_EXP_BASE + WAIT_EXP_STEP * ((1 << WAIT_SEL_W) - 1);
   localparam int CNT_W        = (MAIN_EXP_MAX > SUB_WAIT_EXP) ? MAIN_EXP_MAX : SUB_WAIT_EXP;
   localparam logic [WAIT_SEL_W-1:0] WAIT_SEL_RST = '1;

   generate
      if (WAIT_EXP_BASE < 1 || SUB_WAIT_EXP < 1) begin : g_bad_exp
         $error("wait exponents must be at least 1");
      end
      if (CNT_W > 31) begin : g_bad_width
         $error("wait counter wider than 31 bits");
      end
      if (WAIT_EXP_STEP < 0) begin : g_bad_step
         $error("wait step must not be negative");
      end
   endgenerate

   src_e                  cur_src_e;
   logic                  main_halt_q, sub_halt_q, auto_halt_q;
   logic [WAIT_SEL_W-1:0] wait_sel_q;
   logic [NUM_OSC-1:0]    osc_en, osc_rdy;
   logic [CNT_W-1:0]      osc_last [NUM_OSC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_sel_q  <= WAIT_SEL_RST;
         auto_halt_q <= 1'b0;
      end else begin
         if (wait_sel_wr)  wait_sel_q  <= wait_sel_val;
         if (auto_halt_wr) auto_halt_q <= auto_halt_val;
      end
   end

   // Main wait length: fixed when the step is zero, otherwise chosen by the field.
   generate
      if (WAIT_EXP_STEP == 0) begin : g_main_fixed
         assign osc_last[OSC_MAIN] = {CNT_W{1'b1}} >> (CNT_W - WAIT_EXP_BASE);
      end else begin : g_main_sel
         int unsigned main_exp;
         always_comb begin
            main_exp           = WAIT_EXP_BASE + WAIT_EXP_STEP * int'(wait_sel_q);
            osc_last[OSC_MAIN] = {CNT_W{1'b1}} >> (CNT_W - main_exp);
         end
      end
   endgenerate
   assign osc_last[OSC_SUB] = {CNT_W{1'b1}} >> (CNT_W - SUB_WAIT_EXP);

   assign osc_en[OSC_MAIN] = !main_halt_q && !(stop_grant && auto_halt_q);
   assign osc_en[OSC_SUB]  = !sub_halt_q;

   generate
      for (genvar i = 0; i < NUM_OSC; i++) begin : g_osc
         csg_osc_timer #(.CNT_W(CNT_W)) u_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (osc_en[i]),
            .last  (osc_last[i]),
            .rdy   (osc_rdy[i])
         );
      end
   endgenerate

   assign busy = |(osc_en & ~osc_rdy);

   csg_src_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_vld       (src_req_vld),
      .req_code      (src_req_code),
      .main_halt_wr  (main_halt_wr),
      .main_halt_val (main_halt_val),
      .sub_halt_wr   (sub_halt_wr),
      .sub_halt_val  (sub_halt_val),
      .err_clr       (err_clr),
      .busy          (busy),
      .cur_src       (cur_src_e),
      .main_halt     (main_halt_q),
      .sub_halt      (sub_halt_q),
      .err           (err)
   );

   csg_stop_gate u_stop (
      .clk       (clk),
      .rst_n     (rst_n),
      .stop_req  (stop_req),
      .auto_halt (auto_halt_q),
      .cur_src   (cur_src_e),
      .busy      (busy),
      .grant     (stop_grant)
   );

   assign cur_src     = cur_src_e;
   assign main_osc_en = osc_en[OSC_MAIN];
   assign sub_osc_en  = osc_en[OSC_SUB];
   assign main_rdy    = osc_rdy[OSC_MAIN];
   assign sub_rdy     = osc_rdy[OSC_SUB];
endmodule

// File: rtl/csg_checker.sv
module csg_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       src_req_vld,
   input logic [1:0] src_req_code,
   input logic       main_osc_en,
   input logic       sub_osc_en,
   input logic       stop_req,
   input logic       stop_grant,
   input logic       err,
   input logic       busy,
   input logic [1:0] cur_src,
   input logic       main_halt,
   input logic       auto_halt
);
   AST_MAIN_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (src_req_vld && src_req_code != 2'b11 && main_halt) |=> err);              // R2
   AST_SUB_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (src_req_vld && src_req_code == 2'b11 && !sub_osc_en) |=> err);            // R3
   AST_HALT_STOPS_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
      main_halt |-> !main_osc_en);                                                // R4
   AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cur_src));                                                 // R7
   AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      stop_grant |-> $past(stop_req));                                            // R10
   AST_GRANT_PLL_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_grant |-> $past(auto_halt || cur_src == 2'b00));                       // R10
   AST_AUTO_HALT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_grant && auto_halt) |-> !main_osc_en);                                // R11
endmodule

bind clk_src_guard csg_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .src_req_vld  (src_req_vld),
   .src_req_code (src_req_code),
   .main_osc_en  (main_osc_en),
   .sub_osc_en   (sub_osc_en),
   .stop_req     (stop_req),
   .stop_grant   (stop_grant),
   .err          (err),
   .busy         (busy),
   .cur_src      (cur_src),
   .main_halt    (main_halt_q),
   .auto_halt    (auto_halt_q)
);

// File: tb/clk_src_guard_tb.sv
`timescale 1ns/1ps
module clk_src_guard_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic src_req_vld = 0, main_halt_wr = 0, main_halt_val = 0, sub_halt_wr = 0, sub_halt_val = 0;
   logic wait_sel_wr = 0, auto_halt_wr = 0, auto_halt_val = 0, stop_req = 0, err_clr = 0;
   logic [1:0] src_req_code = 2'b00, wait_sel_val = 2'b00;
   logic [1:0] cur_src;
   logic busy, err, main_osc_en, sub_osc_en, main_rdy, sub_rdy, stop_grant;
   int n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;

   clk_src_guard #(.WAIT_EXP_BASE(3), .WAIT_EXP_STEP(1), .SUB_WAIT_EXP(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .src_req_vld(src_req_vld), .src_req_code(src_req_code),
      .main_halt_wr(main_halt_wr), .main_halt_val(main_halt_val),
      .sub_halt_wr(sub_halt_wr), .sub_halt_val(sub_halt_val),
      .wait_sel_wr(wait_sel_wr), .wait_sel_val(wait_sel_val),
      .auto_halt_wr(auto_halt_wr), .auto_halt_val(auto_halt_val),
      .stop_req(stop_req), .err_clr(err_clr), .cur_src(cur_src), .busy(busy), .err(err),
      .main_osc_en(main_osc_en), .sub_osc_en(sub_osc_en), .main_rdy(main_rdy),
      .sub_rdy(sub_rdy), .stop_grant(stop_grant));

   task automatic chk(input int act, input int exp, input string what);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic req(input logic [1:0] code);
      src_req_code = code; src_req_vld = 1'b1; cyc(1); src_req_vld = 1'b0;
   endtask
   task automatic halt_main(input logic v);
      main_halt_val = v; main_halt_wr = 1'b1; cyc(1); main_halt_wr = 1'b0;
   endtask
   task automatic halt_sub(input logic v);
      sub_halt_val = v; sub_halt_wr = 1'b1; cyc(1); sub_halt_wr = 1'b0;
   endtask
   task automatic clear_err();
      err_clr = 1'b1; cyc(1); err_clr = 1'b0;
   endtask

   task automatic t_reset_exit();
      rst_n = 1'b0; cyc(2);
      chk(cur_src, 0, "R9 source in reset");
      chk(err, 0, "R9 error in reset");
      chk(main_osc_en, 1, "R9 main enabled in reset");
      rst_n = 1'b1;
      cyc(63);
      chk(busy, 1, "R9 busy before longest wait ends");
      cyc(1);
      chk(busy, 0, "R9 busy after 64 cycles");
      chk(main_rdy, 1, "R5 main ready");
      chk(stop_grant, 0, "R10 no grant without request");
   endtask

   task automatic t_switch();
      req(2'b10); chk(cur_src, 2, "R1 select PLL");
      req(2'b01); chk(cur_src, 1, "R1 select main direct");
   endtask

   task automatic t_halt_rules();
      halt_main(1'b1);
      chk(err, 1, "R4 main halt refused on main");
      chk(main_osc_en, 1, "R4 main still enabled");
      err_clr = 1'b1; cyc(1); err_clr = 1'b0;
      chk(err, 0, "R8 error cleared");
      req(2'b11); chk(cur_src, 3, "R1 select sub");
      halt_sub(1'b1);
      chk(err, 1, "R4 sub halt refused on sub");
      chk(sub_osc_en, 1, "R4 sub still enabled");
      clear_err();
      halt_main(1'b1);
      chk(err, 0, "R4 main halt accepted on sub");
      chk(main_osc_en, 0, "R4 main disabled");
      req(2'b00);
      chk(err, 1, "R2 main code refused");
      chk(cur_src, 3, "R2 source unchanged");
      cyc(3);
      chk(err, 1, "R8 error sticky");
      clear_err();
   endtask

   task automatic t_main_return();
      wait_sel_val = 2'b00; wait_sel_wr = 1'b1; cyc(1); wait_sel_wr = 1'b0;
      halt_main(1'b0);
      chk(busy, 1, "R5 busy on main restart");
      req(2'b01);
      chk(cur_src, 3, "R7 request queued during wait");
      chk(err, 0, "R7 queued request not an error");
      cyc(4);
      chk(busy, 1, "R6 wait of 8 still running");
      cyc(6);
      chk(busy, 0, "R6 wait of 8 finished");
      chk(cur_src, 1, "R7 pending request applied");
   endtask

   task automatic t_sub_return();
      halt_sub(1'b1);
      chk(sub_osc_en, 0, "R4 sub halt accepted on main");
      req(2'b11);
      chk(err, 1, "R3 sub code refused");
      chk(cur_src, 1, "R3 source unchanged");
      clear_err();
      halt_sub(1'b0);
      req(2'b00);
      req(2'b11);
      cyc(12);
      chk(cur_src, 1, "R7 still waiting on sub");
      cyc(6);
      chk(busy, 0, "R6 sub wait of 16 finished");
      chk(cur_src, 3, "R7 latest pending applied");
   endtask

   task automatic t_stop();
      req(2'b10);
      stop_req = 1'b1; cyc(3);
      chk(stop_grant, 0, "R10 no grant on PLL");
      req(2'b00); cyc(1);
      chk(stop_grant, 1, "R10 grant on main/2");
      stop_req = 1'b0; cyc(1);
      chk(stop_grant, 0, "R10 grant falls with request");
      auto_halt_val = 1'b1; auto_halt_wr = 1'b1; cyc(1); auto_halt_wr = 1'b0;
      req(2'b10);
      stop_req = 1'b1; cyc(2);
      chk(stop_grant, 1, "R10 grant on PLL with auto-halt");
      chk(main_osc_en, 0, "R11 main halted in stop");
      stop_req = 1'b0; cyc(1);
      chk(main_osc_en, 1, "R11 main restarts");
      chk(busy, 1, "R11 wait runs again");
      cyc(8);
      chk(busy, 0, "R11 wait done");
   endtask

   task automatic t_reset_halted();
      req(2'b11);
      halt_main(1'b1);
      chk(main_osc_en, 0, "R9 main halted before reset");
      t_reset_exit();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      cyc(1);
      t_reset_exit();
      t_switch();
      t_halt_rules();
      t_main_return();
      t_sub_return();
      t_stop();
      t_reset_halted();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule